// File: doc/BRIEF.md
# Positive-Justification Elastic Store Transmitter

This block is the transmit side of one tributary in an asynchronous bit-interleaved multiplexer. Tributary bits arrive on a valid/ready stream. They are written into an eight-entry elastic store that comes out of reset half full. The frame sequencer offers this tributary one slot per `slot_en` strobe and tags each slot as data, overhead, control or justifiable. Data slots read the store. Overhead slots (alignment word, service bits) read nothing and emit nothing. The sequencer offers read slots faster than the tributary writes, so the store drains slowly over time. That is positive justification.

Once per frame, at the first control slot, the block compares the store's fill level with a threshold of 2. If the fill is below the threshold, the frame is a stuff frame: the justifiable slot carries a dummy 0 and no bit is read, so the store gains one bit of slack against the writer. Each control slot carries the frame's decision. The decision is repeated over 3 control slots in the lower-rate mode and 5 in the higher-rate mode, and the far end can take a majority vote. The sequencer may place these control slots anywhere in the frame.

Back-pressure rules: `trib_ready` is high exactly when the store holds fewer than 8 bits. A bit is accepted only when `trib_valid` and `trib_ready` are both high. A real tributary cannot wait, so a bit offered while `trib_ready` is low is dropped and flagged. The output side has no ready signal, because the frame timing fixes when slots occur. `out_valid` marks each slot that carries a bit.

Top module: `justif_tx`

## Requirements
- R1: After reset, the store holds 4 zero bits, so `trib_ready` is 1. `out_valid`, `stuff_this_frame`, `overflow` and `underflow` are 0.
- R2: A data slot (`slot_type` 2'b00) reads the oldest stored bit. On the next cycle the block presents that bit on `out_bit` with `out_valid` high. Bits leave in the order they were accepted.
- R3: An overhead slot (`slot_type` 2'b01) reads nothing, and on the next cycle `out_valid` is 0.
- R4: At the first control slot of a frame, the block sets the stuff decision to (fill < 2), using the fill before that cycle's write. `stuff_this_frame` shows the new decision one cycle later and holds it until the next frame's first control slot.
- R5: The first NCTRL control slots (`slot_type` 2'b10) after a justifiable slot each emit one bit equal to the decision: 1 for stuff, 0 for data. NCTRL is 3 when `HIGH_RATE` is 0 and 5 when it is 1. Any further control slots before the next justifiable slot emit nothing.
- R6: In a stuff frame, the justifiable slot (`slot_type` 2'b11) emits a valid 0 and reads nothing. Otherwise it behaves like a data slot. A justifiable slot also restarts the control-slot count.
- R7: `trib_ready` equals (fill < 8). A bit is stored when `trib_valid` and `trib_ready` are both high. A read and a write in the same cycle leave the fill unchanged.
- R8: If `trib_valid` is high while `trib_ready` is low, the bit is dropped and `overflow` goes to 1 and stays there until reset.
- R9: A read from an empty store emits a valid 0, leaves the fill at 0, and sets `underflow` to 1 until reset.
- R10: A cycle with `slot_en` low reads nothing, and on the next cycle `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | This tributary owns the current slot |
| slot_type | input | 2 | 00 data, 01 overhead, 10 control, 11 justifiable |
| trib_valid | input | 1 | Tributary bit offered |
| trib_ready | output | 1 | Store can accept a bit |
| trib_bit | input | 1 | Tributary data bit |
| out_valid | output | 1 | `out_bit` carries a slot bit |
| out_bit | output | 1 | Data, control or stuff bit |
| stuff_this_frame | output | 1 | Current frame's justification decision |
| overflow | output | 1 | Sticky: a bit was dropped |
| underflow | output | 1 | Sticky: the store was read while empty |

## Verification
`out_valid`, `out_bit`, `stuff_this_frame`, `overflow` and `underflow` are registered, so each one reflects the slot and write presented one clock earlier. `trib_ready` follows from the registered fill and is correct in the same cycle as the offered bit. The driver records each expected result with the cycle in which it was presented. The monitor compares that result only at the falling edge after the next rising edge. The driver checks `trib_ready` just after each rising edge, before it drives new inputs.

// File: rtl/jtx_pkg.sv
package jtx_pkg;
  typedef enum logic [1:0] {
    SLOT_DATA = 2'b00,
    SLOT_OVH  = 2'b01,
    SLOT_CTRL = 2'b10,
    SLOT_JUST = 2'b11
  } slot_e;

  function automatic int ctrl_count(input bit high_rate);
    return high_rate ? 5 : 3;
  endfunction
endpackage

// File: rtl/jtx_store.sv
module jtx_store #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wr_bit,
  output logic          wr_ok,
  input  logic          rd_req,
  output logic          rd_bit,
  output logic          empty,
  output logic [CW-1:0] fill,
  output logic          ovf,
  output logic          udf
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DEPTH-1:0] cells;
  logic [AW-1:0]    wp, rp;
  logic             wr_do, rd_do;

  assign wr_ok  = (fill != FULL_LVL);
  assign empty  = (fill == '0);
  assign wr_do  = wr_req && wr_ok;
  assign rd_do  = rd_req && !empty;
  assign rd_bit = cells[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= '0;
      wp    <= AW'(DEPTH / 2);
      rp    <= '0;
      fill  <= HALF_LVL;
      ovf   <= 1'b0;
      udf   <= 1'b0;
    end else begin
      if (wr_do) begin
        cells[wp] <= wr_bit;
        wp        <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      end
      if (rd_do) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      case ({wr_do, rd_do})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (wr_req && !wr_ok) ovf <= 1'b1;
      if (rd_req && empty)  udf <= 1'b1;
    end
  end

  // R7
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);
  // R7
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FULL_LVL && wr_req && !rd_req) |=> (fill == FULL_LVL));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R9
  udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> (fill == '0) && udf);
endmodule

// File: rtl/jtx_decide.sv
module jtx_decide
  import jtx_pkg::*;
#(
  parameter int NCTRL  = 3,
  parameter int THRESH = 2,
  parameter int CW     = 4,
  parameter int CNW    = $clog2(NCTRL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_en,
  input  slot_e         slot_type,
  input  logic [CW-1:0] fill,
  output logic          ctrl_live,
  output logic          stuff_now,
  output logic          stuff_q
);
  localparam logic [CNW-1:0] CNT_LIM = CNW'(NCTRL);
  localparam logic [CW-1:0]  THR_LVL = CW'(THRESH);

  logic [CNW-1:0] cnt;
  logic           take;

  assign ctrl_live = slot_en && (slot_type == SLOT_CTRL) && (cnt < CNT_LIM);
  assign take      = ctrl_live && (cnt == '0);
  assign stuff_now = take ? (fill < THR_LVL) : stuff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      stuff_q <= 1'b0;
    end else begin
      if (take) stuff_q <= (fill < THR_LVL);
      if (slot_en && slot_type == SLOT_JUST) cnt <= '0;
      else if (ctrl_live)                    cnt <= cnt + 1'b1;
    end
  end

  // R4
  stuff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_en && slot_type == SLOT_CTRL) |=> $stable(stuff_q));
  // R5
  ctrl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_LIM);
endmodule

// File: rtl/jtx_emit.sv
module jtx_emit
  import jtx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_en,
  input  slot_e slot_type,
  input  logic  ctrl_live,
  input  logic  stuff_now,
  input  logic  rd_bit,
  input  logic  empty,
  output logic  rd_req,
  output logic  out_valid,
  output logic  out_bit
);
  logic nxt_valid, nxt_bit;

  always_comb begin
    rd_req    = 1'b0;
    nxt_valid = 1'b0;
    nxt_bit   = 1'b0;
    if (slot_en) begin
      unique case (slot_type)
        SLOT_DATA: begin
          rd_req    = 1'b1;
          nxt_valid = 1'b1;
          nxt_bit   = rd_bit && !empty;
        end
        SLOT_CTRL: begin
          nxt_valid = ctrl_live;
          nxt_bit   = ctrl_live && stuff_now;
        end
        SLOT_JUST: begin
          rd_req    = !stuff_now;
          nxt_valid = 1'b1;
          nxt_bit   = !stuff_now && rd_bit && !empty;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= nxt_valid;
      out_bit   <= nxt_bit;
    end
  end

  // R3
  ovh_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot_type == SLOT_OVH) |=> !out_valid);
  // R10
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> !out_valid);
  // R6
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && slot_type == SLOT_JUST && stuff_now) |=> (out_valid && !out_bit));
endmodule

// File: rtl/justif_tx.sv
module justif_tx
  import jtx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int THRESH    = 2,
  parameter bit HIGH_RATE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_en,
  input  logic [1:0] slot_type,
  input  logic       trib_valid,
  output logic       trib_ready,
  input  logic       trib_bit,
  output logic       out_valid,
  output logic       out_bit,
  output logic       stuff_this_frame,
  output logic       overflow,
  output logic       underflow
);
  localparam int NCTRL = ctrl_count(HIGH_RATE);
  localparam int CW    = $clog2(DEPTH + 1);

  slot_e         st;
  logic [CW-1:0] fill;
  logic          rd_req, rd_bit, empty, ctrl_live, stuff_now;

  assign st = slot_e'(slot_type);

  jtx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(trib_valid), .wr_bit(trib_bit), .wr_ok(trib_ready),
    .rd_req(rd_req), .rd_bit(rd_bit), .empty(empty), .fill(fill),
    .ovf(overflow), .udf(underflow)
  );

  jtx_decide #(.NCTRL(NCTRL), .THRESH(THRESH), .CW(CW)) u_decide (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_type(st),
    .fill(fill), .ctrl_live(ctrl_live), .stuff_now(stuff_now),
    .stuff_q(stuff_this_frame)
  );

  jtx_emit u_emit (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_type(st),
    .ctrl_live(ctrl_live), .stuff_now(stuff_now), .rd_bit(rd_bit),
    .empty(empty), .rd_req(rd_req), .out_valid(out_valid), .out_bit(out_bit)
  );
endmodule

// File: tb/sim_justif_tx.sv
module sim_justif_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_en = 1'b0, trib_valid = 1'b0, trib_bit = 1'b0;
  logic [1:0] slot_type = 2'b00;
  logic trib_ready, out_valid, out_bit, stuff_this_frame, overflow, underflow;

  always #2 clk = ~clk;

  justif_tx u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .slot_type(slot_type),
    .trib_valid(trib_valid), .trib_ready(trib_ready), .trib_bit(trib_bit),
    .out_valid(out_valid), .out_bit(out_bit), .stuff_this_frame(stuff_this_frame),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct {
    logic v; logic b; logic st; logic ov; logic ud; int cyc; string req;
  } exp_t;

  exp_t sbq[$];
  logic mq[$];
  int   mcnt, cyc = 0, n_chk = 0, n_bad = 0;
  logic mstuff, movf, mudf;
  logic [7:0] lfsr = 8'hA5;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mq = {1'b0, 1'b0, 1'b0, 1'b0};
    mcnt = 0; mstuff = 1'b0; movf = 1'b0; mudf = 1'b0;
  endtask

  task automatic step(input logic en, input logic [1:0] ty,
                      input logic wv, input logic wb);
    exp_t e;
    int pre;
    @(posedge clk); #1;
    pre = mq.size();
    // R7: ready tracks fill < 8
    chk(trib_ready == (pre < 8), "R7", "trib_ready", trib_ready, pre < 8);
    e.v = 1'b0; e.b = 1'b0; e.req = "R10";
    if (en) begin
      case (ty)
        2'b00: begin
          e.v = 1'b1; e.req = "R2";
          if (pre > 0) e.b = mq.pop_front(); else begin e.b = 1'b0; mudf = 1'b1; e.req = "R9"; end
        end
        2'b01: e.req = "R3";
        2'b10: begin
          e.req = "R5";
          if (mcnt < 3) begin
            if (mcnt == 0) mstuff = (pre < 2);
            e.v = 1'b1; e.b = mstuff; mcnt++;
          end
        end
        default: begin
          mcnt = 0; e.v = 1'b1; e.req = "R6";
          if (!mstuff) begin
            if (pre > 0) e.b = mq.pop_front(); else begin e.b = 1'b0; mudf = 1'b1; end
          end
        end
      endcase
    end
    if (wv) begin
      if (pre < 8) mq.push_back(wb); else movf = 1'b1;
    end
    e.st = mstuff; e.ov = movf; e.ud = mudf; e.cyc = cyc;
    sbq.push_back(e);
    slot_en = en; slot_type = ty; trib_valid = wv; trib_bit = wb;
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].cyc < cyc) begin
      exp_t e;
      e = sbq.pop_front();
      chk(out_valid == e.v, e.req, "out_valid", out_valid, e.v);
      if (e.v) chk(out_bit == e.b, e.req, "out_bit", out_bit, e.b);
      // R4
      chk(stuff_this_frame == e.st, "R4", "stuff_this_frame", stuff_this_frame, e.st);
      // R8
      chk(overflow == e.ov, "R8", "overflow", overflow, e.ov);
      // R9
      chk(underflow == e.ud, "R9", "underflow", underflow, e.ud);
    end
  end

  task automatic do_reset();
    repeat (3) step(1'b0, 2'b00, 1'b0, 1'b0);
    @(posedge clk); #1;
    slot_en = 1'b0; trib_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    sbq.delete();
    model_reset();
  endtask

  task automatic run_frame(input int k, input bit extra_ctrl);
    for (int p = 0; p < 16; p++) begin
      logic [1:0] ty;
      logic wv;
      if (p == 0) ty = 2'b01;
      else if (p == 3 || p == 8 || p == 13 || (extra_ctrl && p == 5)) ty = 2'b10;
      else if (p == 15) ty = 2'b11;
      else ty = 2'b00;
      wv = (ty == 2'b00) || (ty == 2'b11 && (k % 2 == 0));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b1, ty, wv, lfsr[0]);
    end
    step(1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n_stuff = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(trib_ready == 1'b1, "R1", "trib_ready", trib_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(stuff_this_frame == 1'b0, "R1", "stuff_this_frame", stuff_this_frame, 0);
    chk(overflow == 1'b0 && underflow == 1'b0, "R1", "flags", {overflow, underflow}, 0);

    // R9: drain the four reset zeros, then read empty; R3 and R10 slots interleaved
    step(1'b1, 2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b0);
    step(1'b1, 2'b00, 1'b1, 1'b1);
    do_reset();

    // R7 / R8: fill to 8, drop one bit, then read back in order (R2)
    step(1'b0, 2'b00, 1'b1, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b0);
    step(1'b0, 2'b00, 1'b1, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b1);
    step(1'b0, 2'b00, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, 2'b00, 1'b0, 1'b0);
    do_reset();

    // R4 / R5 / R6: frames with the read side slightly faster than the writes
    for (int k = 0; k < 24; k++) begin
      run_frame(k, 1'b0);
      @(negedge clk);
      if (stuff_this_frame) n_stuff++;
    end
    // R4: both stuff and data frames must have occurred
    chk(n_stuff > 0 && n_stuff < 24, "R4", "stuff frame count", n_stuff, 9);
    // R5: a frame carrying a surplus control slot
    run_frame(24, 1'b1);
    run_frame(25, 1'b0);
    repeat (3) step(1'b0, 2'b00, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule